// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Preset

This block is a small synchronous binary counter. It counts up or down, wraps modulo 2^WIDTH (WIDTH = 4 by default, so modulo 16), and can be preset from a parallel data bus. Every change of state happens on the rising clock edge. A synchronous active-high reset is provided for test use only, so that simulation starts from a known value.

Control is active-low. A low preset strobe loads the data bus and takes priority over everything except reset. Counting needs both count enables low. One of them, the parallel enable, only gates this stage. The other, the trickle enable, also gates the terminal-count flag. The flag is an active-low combinational decode of the state. It marks the last value before wrap in the current direction. Several counters can be chained by driving each stage's trickle enable from the flag of the stage below, with the parallel enable shared by all stages. The flag is a decode and may glitch, so it must never be used as a clock.

Top module: `updn_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0. Reset overrides all other inputs.
- R2: With `rst` low and `load_n` low at a rising edge, `q` takes the value of `pdata`, whatever `cep_n`, `cet_n` and `up_dn` are.
- R3: With `load_n` high, `cep_n` low, `cet_n` low and `up_dn` high (1 = up), `q` increments by one at the edge. The all-ones value wraps to 0.
- R4: Under the same enables with `up_dn` low (0 = down), `q` decrements by one at the edge. 0 wraps to all-ones.
- R5: With `load_n` high and either `cep_n` or `cet_n` high, `q` holds its value across the edge.
- R6: In the same cycle, `tc_n` is low exactly when `cet_n` is low and either `up_dn` is high with `q` all-ones, or `up_dn` is low with `q` zero. Otherwise `tc_n` is high.
- R7: The level of `cep_n` has no effect on `tc_n`.
- R8: Two 4-bit instances chained as described above, with `load_n`, `up_dn` and `cep_n` shared, behave as one 8-bit up/down counter. The upper stage's `tc_n` serves as the 8-bit terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, test use |
| load_n | input | 1 | Active-low preset strobe |
| pdata | input | WIDTH | Preset value |
| cep_n | input | 1 | Active-low count enable, local to this stage |
| cet_n | input | 1 | Active-low count enable, also gates `tc_n` |
| up_dn | input | 1 | Direction: 1 up, 0 down |
| q | output | WIDTH | Counter state |
| tc_n | output | 1 | Active-low terminal count |

## Verification
Two functions can be active in the same cycle: a preset request together with an enabled count, and a terminal-count decode while the parallel enable forbids counting. The bench sweeps all sixteen combinations of preset strobe, both enables and direction from every starting value. Each combination is judged against an arithmetic model. That model gives the preset precedence and checks the flag using only the trickle enable, the direction and the state. A chained pair is then run across the 8-bit wrap in both directions, and its combined value is compared with a modulo-256 model.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } updn_op_e;

  // One count step, masked to w bits.
  function automatic logic [31:0] step_value(input logic [31:0] v, input int w, input logic up);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return up ? ((v + 32'd1) & mask) : ((v - 32'd1) & mask);
  endfunction

  // True on the last value before wrap in the given direction.
  function automatic logic at_terminal(input logic [31:0] v, input int w, input logic up);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return up ? ((v & mask) == mask) : ((v & mask) == 32'd0);
  endfunction

endpackage

// File: rtl/updn_ctl.sv
`timescale 1ns/1ps
module updn_ctl
  import updn_pkg::*;
(
  input  logic     load_n,
  input  logic     cep_n,
  input  logic     cet_n,
  input  logic     up_dn,
  output updn_op_e op
);

  logic count_ok;
  assign count_ok = !cep_n && !cet_n;

  always_comb begin
    if (!load_n)       op = OP_LOAD;
    else if (count_ok) op = up_dn ? OP_INC : OP_DEC;
    else               op = OP_HOLD;
  end

endmodule

// File: rtl/updn_reg.sv
`timescale 1ns/1ps
module updn_reg
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  updn_op_e         op,
  input  logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [31:0]      inc_w;
  logic [31:0]      dec_w;
  logic [WIDTH-1:0] q_inc;
  logic [WIDTH-1:0] q_dec;

  assign inc_w = step_value(32'(q), WIDTH, 1'b1);
  assign dec_w = step_value(32'(q), WIDTH, 1'b0);
  assign q_inc = inc_w[WIDTH-1:0];
  assign q_dec = dec_w[WIDTH-1:0];

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      case (op)
        OP_LOAD: q <= pdata;
        OP_INC:  q <= q_inc;
        OP_DEC:  q <= q_dec;
        default: q <= q;
      endcase
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_LOAD) |-> q == $past(pdata));

  assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_INC) |-> (q - $past(q)) == ONE);

  assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_DEC) |-> ($past(q) - q) == ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_HOLD) |-> $stable(q));

endmodule

// File: rtl/updn_tc.sv
`timescale 1ns/1ps
module updn_tc
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_dn,
  input  logic             cet_n,
  output logic             tc_n
);

  logic at_end;
  assign at_end = at_terminal(32'(q), WIDTH, up_dn);
  assign tc_n   = !(at_end && !cet_n);

endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] pdata,
  input  logic             cep_n,
  input  logic             cet_n,
  input  logic             up_dn,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);

  updn_op_e op;

  updn_ctl ctl_i (
    .load_n (load_n),
    .cep_n  (cep_n),
    .cet_n  (cet_n),
    .up_dn  (up_dn),
    .op     (op)
  );

  updn_reg #(.WIDTH(WIDTH)) reg_i (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .pdata (pdata),
    .q     (q)
  );

  updn_tc #(.WIDTH(WIDTH)) tc_i (
    .q     (q),
    .up_dn (up_dn),
    .cet_n (cet_n),
    .tc_n  (tc_n)
  );

  // A flagged stage that is allowed to count must wrap on the next edge.
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tc_n) && $past(load_n) && !$past(cep_n))
      |-> q == ($past(up_dn) ? {WIDTH{1'b0}} : {WIDTH{1'b1}}));

  // The flag needs the trickle enable low.
  assert_tc_gate_R6: assert property (@(posedge clk) disable iff (rst)
    cet_n |-> tc_n);

endmodule

// File: tb/updn_counter_tb.sv
`timescale 1ns/1ps
module updn_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  // single stage
  logic         load_n = 1'b1, cep_n = 1'b1, cet_n = 1'b1, up_dn = 1'b1;
  logic [W-1:0] pdata = '0;
  logic [W-1:0] q;
  logic         tc_n;

  updn_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .load_n(load_n), .pdata(pdata),
    .cep_n(cep_n), .cet_n(cet_n), .up_dn(up_dn), .q(q), .tc_n(tc_n)
  );

  // chained pair
  logic       c_load_n = 1'b1, c_cep_n = 1'b1, c_cet_n = 1'b1, c_up = 1'b1;
  logic [7:0] c_data = '0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc_n, hi_tc_n;

  updn_counter #(.WIDTH(4)) lo_i (
    .clk(clk), .rst(rst), .load_n(c_load_n), .pdata(c_data[3:0]),
    .cep_n(c_cep_n), .cet_n(c_cet_n), .up_dn(c_up), .q(lo_q), .tc_n(lo_tc_n)
  );
  updn_counter #(.WIDTH(4)) hi_i (
    .clk(clk), .rst(rst), .load_n(c_load_n), .pdata(c_data[7:4]),
    .cep_n(c_cep_n), .cet_n(lo_tc_n), .up_dn(c_up), .q(hi_q), .tc_n(hi_tc_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Entered just after a falling edge, left at the next falling edge.
  task automatic apply1(input logic ld, input logic p, input logic t,
                        input logic u, input int d, inout int model);
    int exp_tc;
    string req;
    load_n = ld; cep_n = p; cet_n = t; up_dn = u; pdata = W'(d);
    #1;
    exp_tc = (!t && ((u && model == 15) || (!u && model == 0))) ? 0 : 1;
    check(p ? "R7 tc_n with cep_n high" : "R6 tc_n decode", int'(tc_n), exp_tc);
    if (!ld) begin model = d & 15; req = "R2 load precedence"; end
    else if (!p && !t) begin
      model = u ? (model + 1) % 16 : (model + 15) % 16;
      req = u ? "R3 count up" : "R4 count down";
    end else req = "R5 hold";
    @(negedge clk);
    check(req, int'(q), model);
  endtask

  task automatic apply2(input logic ld, input logic p, input logic t,
                        input logic u, input int d, inout int model);
    int exp_tc;
    c_load_n = ld; c_cep_n = p; c_cet_n = t; c_up = u; c_data = 8'(d);
    #1;
    exp_tc = (!t && ((u && model == 255) || (!u && model == 0))) ? 0 : 1;
    check("R8 cascade terminal count", int'(hi_tc_n), exp_tc);
    if (!ld) model = d & 255;
    else if (!p && !t) model = u ? (model + 1) % 256 : (model + 255) % 256;
    @(negedge clk);
    check("R8 cascade value", int'({hi_q, lo_q}), model);
  endtask

  initial begin
    int m;
    int m2;
    m = 0; m2 = 0;
    // R1: reset with a load pending; reset must win
    load_n = 1'b0; pdata = 4'd9; c_load_n = 1'b0; c_data = 8'h5A;
    repeat (2) @(negedge clk);
    check("R1 reset clears", int'(q), 0);
    check("R1 reset clears cascade", int'({hi_q, lo_q}), 0);
    rst = 1'b0;
    load_n = 1'b1; c_load_n = 1'b1;

    // exhaustive sweep: every start value x every control combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        apply1(1'b0, 1'b1, 1'b1, 1'b1, s, m);
        apply1(c[3], c[2], c[1], c[0], (s * 7 + 3) % 16, m);
      end
    end
    // long runs through both wraps
    for (int i = 0; i < 40; i++) apply1(1'b1, 1'b0, 1'b0, 1'b1, 0, m);
    for (int i = 0; i < 40; i++) apply1(1'b1, 1'b0, 1'b0, 1'b0, 0, m);

    // cascade: up across 255 -> 0, with enable gaps
    apply2(1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, m2);
    for (int i = 0; i < 300; i++)
      apply2(1'b1, (i % 7 == 3), (i % 11 == 5), 1'b1, 0, m2);
    // cascade: down across 0 -> 255
    apply2(1'b0, 1'b0, 1'b0, 1'b0, 8'h10, m2);
    for (int i = 0; i < 300; i++)
      apply2(1'b1, (i % 5 == 2), (i % 13 == 7), 1'b0, 0, m2);
    // cascade: load during enabled count
    apply2(1'b0, 1'b0, 1'b0, 1'b1, 8'hA7, m2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule